// File: doc/BRIEF.md
# Branch Resolution Unit

This unit settles control flow for a simple in-order processor. Each cycle it receives one decoded branch request and answers with a taken or not-taken decision and the address of the next instruction. The request carries the current instruction pointer and an immediate constant. It also carries a general register operand, two operands for a direct compare, the processor's condition flags and a single condition-register bit. Three selectors complete it: one chooses how the target address is formed, one chooses how the condition is tested, and one chooses which condition applies.

The target address can come from five sources. It can be the immediate itself or the register operand. It can be the instruction pointer plus a signed 16-bit distance. It can be the newest entry of an internal return-address stack. It can be an entry read from an internal 16-word interrupt vector table, with the immediate acting as the index. A call request pushes the address that follows the call onto the stack. A return request pops it. Vector lookups go through a registered table read, so they take one extra cycle, and the unit raises `busy` for that cycle.

Top module: `bru_top`

## Requirements
- R1: When `br_valid` is low, when a conditional request's test fails, or when `br_mode` holds an unused code (5 to 7), `taken` is 0 and `next_ip` equals `br_ip + 4`.
- R2: In absolute mode (`br_mode` = 0), a taken request gives `next_ip` = `br_imm`.
- R3: In register-indirect mode (`br_mode` = 1), a taken request gives `next_ip` = `br_reg`.
- R4: In relative mode (`br_mode` = 2), a taken request gives `next_ip` = `br_ip` plus `br_imm[15:0]` sign-extended to 32 bits. Negative distances are included.
- R5: With flag testing (`br_kind` = 1), `flags` is {N,Z,C,V} from bit 3 down to bit 0. `br_sel` 0 takes on Z. `br_sel` 1 takes on !Z. `br_sel` 2 takes on N^V. `br_sel` 3 takes on !(N^V). `br_sel` 4 takes on !C. `br_sel` 5 takes on C. Codes 6 and 7 never take.
- R6: With condition-register testing (`br_kind` = 2), the request is taken exactly when `creg_bit` is 1, whatever `br_sel` holds.
- R7: With compare-and-branch (`br_kind` = 3), `br_sel` 0 takes on `cmp_a == cmp_b`. `br_sel` 1 takes on inequality. `br_sel` 2 takes on signed less-than. `br_sel` 4 takes on unsigned less-than. Every other `br_sel` code never takes.
- R8: A request is taken without testing its condition when any of these holds: `br_kind` = 0, `br_link` = 1, stack mode (`br_mode` = 3), or vector mode (`br_mode` = 4).
- R9: A taken request with `br_link` = 1 outside stack mode pushes `br_ip + 4`. A stack-mode request pops, and its `next_ip` is the most recently pushed address that has not yet been popped.
- R10: The stack holds 8 entries. A push while it is full, or a pop while it is empty, sets `stack_err`. That flag stays set until reset. The stack contents and depth stay unchanged. A pop on an empty stack is still taken, with `next_ip` = `br_ip + 4`.
- R11: A vector-mode request raises `busy` for exactly its own cycle, with `taken` = 0. In the following cycle `busy` is 0, `taken` is 1 and `next_ip` is table entry `br_imm[3:0]`, whose value is 0x2000 + 0x10 × index. Any request presented in that following cycle is ignored.
- R12: After reset the stack is empty, `stack_err` and `busy` are 0, and no vector result is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A branch request is present |
| br_mode | input | 3 | Target source: 0 absolute, 1 register, 2 relative, 3 stack, 4 vector |
| br_kind | input | 2 | Condition style: 0 always, 1 flags, 2 condition bit, 3 compare |
| br_sel | input | 3 | Condition code (see R5, R7) |
| br_link | input | 1 | Call: push the return address |
| br_ip | input | 32 | Address of the branch instruction |
| br_imm | input | 32 | Immediate constant |
| br_reg | input | 32 | Register operand for indirect targets |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| flags | input | 4 | {N,Z,C,V} |
| creg_bit | input | 1 | Explicit condition register bit |
| taken | output | 1 | Branch redirects fetch |
| next_ip | output | 32 | Next instruction address |
| busy | output | 1 | Vector lookup in progress; `next_ip` not yet valid |
| stack_err | output | 1 | Sticky stack overflow or underflow |

## Verification
The bench fills the return stack to its limit and pushes once more. It then expects exactly eight returns, in reverse order, with the ninth address missing. A design that wrapped or advanced its pointer would overwrite the oldest entry or return garbage. A return on an empty stack must still be taken and must fall through to `br_ip + 4` while setting the sticky error flag. A unit that underflowed its pointer would jump to a stale address instead. The vector test presents a call during the result cycle and then checks that the next return still sees the earlier address. A design that kept accepting requests while finishing a lookup would leak that push. The signed and unsigned comparisons use a negative operand against a positive one, so that swapping the two comparison styles gives the wrong answer.

// File: rtl/bru_pkg.sv
package bru_pkg;

    typedef enum logic [2:0] {
        TM_ABS = 3'd0,
        TM_REG = 3'd1,
        TM_REL = 3'd2,
        TM_STK = 3'd3,
        TM_VEC = 3'd4
    } tgt_mode_e;

    typedef enum logic [1:0] {
        CK_ALWAYS = 2'd0,
        CK_FLAGS  = 2'd1,
        CK_CREG   = 2'd2,
        CK_CMP    = 2'd3
    } cond_kind_e;

    typedef enum logic [2:0] {
        CS_EQ  = 3'd0,
        CS_NE  = 3'd1,
        CS_LT  = 3'd2,
        CS_GE  = 3'd3,
        CS_LTU = 3'd4,
        CS_GEU = 3'd5
    } cond_sel_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    // Evaluate a flag-based condition code.
    function automatic logic flag_test(input logic [2:0] sel, input flags_t f);
        logic r;
        case (sel)
            CS_EQ:   r = f.z;
            CS_NE:   r = !f.z;
            CS_LT:   r = f.n ^ f.v;
            CS_GE:   r = !(f.n ^ f.v);
            CS_LTU:  r = !f.c;
            CS_GEU:  r = f.c;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bru_cond.sv
module bru_cond
    import bru_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   kind,
    input  logic [2:0]   sel,
    input  logic [3:0]   flags,
    input  logic         creg_bit,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         hit
);

    logic cmp_hit;

    always_comb begin
        case (sel)
            CS_EQ:   cmp_hit = (a == b);
            CS_NE:   cmp_hit = (a != b);
            CS_LT:   cmp_hit = ($signed(a) < $signed(b));
            CS_LTU:  cmp_hit = (a < b);
            default: cmp_hit = 1'b0;
        endcase
    end

    always_comb begin
        case (kind)
            CK_ALWAYS: hit = 1'b1;
            CK_FLAGS:  hit = flag_test(sel, flags_t'(flags));
            CK_CREG:   hit = creg_bit;
            default:   hit = cmp_hit;
        endcase
    end

endmodule

// File: rtl/bru_ras.sv
module bru_ras #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         err
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] sp;
    logic [PW-1:0] sp_dec;
    logic          full;

    assign full   = (sp == PW'(DEPTH));
    assign empty  = (sp == '0);
    assign sp_dec = sp - PW'(1);
    assign top    = mem[sp_dec[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp  <= '0;
            err <= 1'b0;
        end else begin
            if ((push && full) || (pop && empty)) begin
                err <= 1'b1;
            end
            if (push && !full) begin
                mem[sp[AW-1:0]] <= push_data;
                sp              <= sp + PW'(1);
            end else if (pop && !empty) begin
                sp <= sp_dec;
            end
        end
    end

    AST_RAS_BOUND: assert property (@(posedge clk) disable iff (rst)
        sp <= PW'(DEPTH));                                              // R10
    AST_RAS_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> (sp == PW'(DEPTH)));                         // R10
    AST_RAS_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> empty);                             // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err);                                                   // R10

endmodule

// File: rtl/bru_vec.sv
module bru_vec #(
    parameter int             W       = 32,
    parameter int             ENTRIES = 16,
    parameter logic [W-1:0]   BASE    = 32'h0000_2000,
    parameter logic [W-1:0]   STRIDE  = 32'h0000_0010
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_en,
    input  logic [$clog2(ENTRIES)-1:0]  rd_idx,
    output logic [W-1:0]                rd_data
);

    logic [W-1:0] tbl [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        assign tbl[g] = BASE + STRIDE * W'(g);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= tbl[rd_idx];
        end
    end

endmodule

// File: rtl/bru_top.sv
module bru_top
    import bru_pkg::*;
#(
    parameter int                 IP_W        = 32,
    parameter int                 IMM_W       = 16,
    parameter int                 RAS_DEPTH   = 8,
    parameter int                 VEC_ENTRIES = 16,
    parameter logic [IP_W-1:0]    VEC_BASE    = 32'h0000_2000,
    parameter logic [IP_W-1:0]    VEC_STRIDE  = 32'h0000_0010
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            br_valid,
    input  logic [2:0]      br_mode,
    input  logic [1:0]      br_kind,
    input  logic [2:0]      br_sel,
    input  logic            br_link,
    input  logic [31:0]     br_ip,
    input  logic [31:0]     br_imm,
    input  logic [31:0]     br_reg,
    input  logic [31:0]     cmp_a,
    input  logic [31:0]     cmp_b,
    input  logic [3:0]      flags,
    input  logic            creg_bit,
    output logic            taken,
    output logic [31:0]     next_ip,
    output logic            busy,
    output logic            stack_err
);

    localparam int                IW      = $clog2(VEC_ENTRIES);
    localparam logic [IP_W-1:0]   INSN_SZ = IP_W'(4);

    logic            cond_hit;
    logic            mode_ok;
    logic            forced;
    logic            go;
    logic            do_push;
    logic            do_pop;
    logic            vec_req;
    logic            pend;
    logic [IP_W-1:0] seq_ip;
    logic [IP_W-1:0] rel_ip;
    logic [IP_W-1:0] target;
    logic [IP_W-1:0] ras_top;
    logic            ras_empty;
    logic [IP_W-1:0] vec_data;

    bru_cond #(.W(IP_W)) u_cond (
        .kind     (br_kind),
        .sel      (br_sel),
        .flags    (flags),
        .creg_bit (creg_bit),
        .a        (cmp_a),
        .b        (cmp_b),
        .hit      (cond_hit)
    );

    bru_ras #(.W(IP_W), .DEPTH(RAS_DEPTH)) u_ras (
        .clk       (clk),
        .rst       (rst),
        .push      (do_push),
        .pop       (do_pop),
        .push_data (seq_ip),
        .top       (ras_top),
        .empty     (ras_empty),
        .err       (stack_err)
    );

    bru_vec #(.W(IP_W), .ENTRIES(VEC_ENTRIES), .BASE(VEC_BASE), .STRIDE(VEC_STRIDE)) u_vec (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (vec_req),
        .rd_idx  (br_imm[IW-1:0]),
        .rd_data (vec_data)
    );

    // Request decode
    always_comb begin
        seq_ip  = br_ip + INSN_SZ;
        rel_ip  = br_ip + {{(IP_W-IMM_W){br_imm[IMM_W-1]}}, br_imm[IMM_W-1:0]};
        mode_ok = (br_mode <= TM_VEC);
        forced  = (br_kind == CK_ALWAYS) || br_link ||
                  (br_mode == TM_STK) || (br_mode == TM_VEC);
        go      = br_valid && !pend && mode_ok && (forced || cond_hit);
        do_pop  = go && (br_mode == TM_STK);
        do_push = go && br_link && (br_mode != TM_STK);
        vec_req = go && (br_mode == TM_VEC);
    end

    // Target selection
    always_comb begin
        case (br_mode)
            TM_ABS:  target = br_imm;
            TM_REG:  target = br_reg;
            TM_REL:  target = rel_ip;
            TM_STK:  target = ras_empty ? seq_ip : ras_top;
            default: target = seq_ip;
        endcase
    end

    // Output steering
    always_comb begin
        if (pend) begin
            taken   = 1'b1;
            next_ip = vec_data;
            busy    = 1'b0;
        end else if (vec_req) begin
            taken   = 1'b0;
            next_ip = seq_ip;
            busy    = 1'b1;
        end else begin
            taken   = go;
            next_ip = go ? target : seq_ip;
            busy    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else begin
            pend <= vec_req;
        end
    end

    AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);                                                // R11
    AST_BUSY_THEN_TAKEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> taken);                                                // R11
    AST_IDLE_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
        (!br_valid && !pend) |-> (!taken && next_ip == br_ip + INSN_SZ)); // R1
    AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(do_push && do_pop));                                          // R9
    AST_STACK_MODE_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (br_valid && !pend && br_mode == TM_STK) |-> taken);            // R8

endmodule

// File: tb/bru_top_tb_top.sv
module bru_top_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] VBASE      = 32'h0000_2000;
    localparam logic [31:0] VSTRIDE    = 32'h0000_0010;

    logic        clk = 1'b0;
    logic        rst;
    logic        br_valid;
    logic [2:0]  br_mode;
    logic [1:0]  br_kind;
    logic [2:0]  br_sel;
    logic        br_link;
    logic [31:0] br_ip;
    logic [31:0] br_imm;
    logic [31:0] br_reg;
    logic [31:0] cmp_a;
    logic [31:0] cmp_b;
    logic [3:0]  flags;
    logic        creg_bit;
    logic        taken;
    logic [31:0] next_ip;
    logic        busy;
    logic        stack_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bru_top dut_i (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_mode(br_mode),
        .br_kind(br_kind), .br_sel(br_sel), .br_link(br_link), .br_ip(br_ip),
        .br_imm(br_imm), .br_reg(br_reg), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .flags(flags), .creg_bit(creg_bit), .taken(taken), .next_ip(next_ip),
        .busy(busy), .stack_err(stack_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic flag_model(input logic [2:0] s, input logic [3:0] f);
        case (s)
            3'd0: return f[2];
            3'd1: return !f[2];
            3'd2: return f[3] ^ f[0];
            3'd3: return !(f[3] ^ f[0]);
            3'd4: return !f[1];
            3'd5: return f[1];
            default: return 1'b0;
        endcase
    endfunction

    task automatic idle();
        @(negedge clk);
        br_valid = 1'b0; br_mode = 3'd0; br_kind = 2'd0; br_sel = 3'd0;
        br_link = 1'b0; br_imm = '0; br_reg = '0;
        #1;
    endtask

    task automatic req(input logic [2:0] m, input logic [1:0] k, input logic [2:0] s,
                       input logic lk, input logic [31:0] ip, input logic [31:0] imm,
                       input logic [31:0] rg);
        @(negedge clk);
        br_valid = 1'b1; br_mode = m; br_kind = k; br_sel = s; br_link = lk;
        br_ip = ip; br_imm = imm; br_reg = rg;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        br_valid = 1'b0; br_mode = '0; br_kind = '0; br_sel = '0; br_link = 1'b0;
        br_ip = 32'h0000_0100; br_imm = '0; br_reg = '0;
        cmp_a = '0; cmp_b = '0; flags = '0; creg_bit = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        idle();
        chk("R12 busy after reset", {31'd0, busy}, 32'd0);
        chk("R12 stack_err after reset", {31'd0, stack_err}, 32'd0);
        chk("R1 idle taken", {31'd0, taken}, 32'd0);
        chk("R1 idle next_ip", next_ip, br_ip + 32'd4);
        req(3'd6, 2'd0, 3'd0, 1'b0, 32'h0000_0500, 32'h0000_9000, '0);
        chk("R1 unused mode taken", {31'd0, taken}, 32'd0);
        chk("R1 unused mode next_ip", next_ip, 32'h0000_0504);
    endtask

    task automatic t_abs();
        req(3'd0, 2'd0, 3'd0, 1'b0, 32'h0000_1000, 32'h00AB_CDE0, '0);
        chk("R2 abs taken", {31'd0, taken}, 32'd1);
        chk("R2 abs next_ip", next_ip, 32'h00AB_CDE0);
    endtask

    task automatic t_reg();
        req(3'd1, 2'd0, 3'd0, 1'b0, 32'h0000_1000, 32'h0, 32'h1234_5678);
        chk("R3 reg next_ip", next_ip, 32'h1234_5678);
    endtask

    task automatic t_rel();
        req(3'd2, 2'd0, 3'd0, 1'b0, 32'h0000_4000, 32'hFFFF_0040, '0);
        chk("R4 rel forward next_ip", next_ip, 32'h0000_4040);
        req(3'd2, 2'd0, 3'd0, 1'b0, 32'h0000_4000, 32'h0000_FFF0, '0);
        chk("R4 rel backward next_ip", next_ip, 32'h0000_3FF0);
    endtask

    task automatic t_flags();
        for (int s = 0; s < 8; s++) begin
            for (int f = 0; f < 16; f++) begin
                flags = 4'(f);
                req(3'd0, 2'd1, 3'(s), 1'b0, 32'h0000_0800, 32'h0000_0C00, '0);
                chk($sformatf("R5 flags sel=%0d f=%0h taken", s, f), {31'd0, taken},
                    {31'd0, flag_model(3'(s), 4'(f))});
                chk($sformatf("R5 flags sel=%0d f=%0h next", s, f), next_ip,
                    flag_model(3'(s), 4'(f)) ? 32'h0000_0C00 : 32'h0000_0804);
            end
        end
        flags = '0;
    endtask

    task automatic t_creg();
        creg_bit = 1'b1;
        req(3'd0, 2'd2, 3'd7, 1'b0, 32'h0000_0800, 32'h0000_0C00, '0);
        chk("R6 creg set taken", {31'd0, taken}, 32'd1);
        creg_bit = 1'b0;
        req(3'd0, 2'd2, 3'd0, 1'b0, 32'h0000_0800, 32'h0000_0C00, '0);
        chk("R6 creg clear taken", {31'd0, taken}, 32'd0);
        chk("R6 creg clear next", next_ip, 32'h0000_0804);
    endtask

    task automatic t_cmp();
        cmp_a = 32'hFFFF_FFFB; cmp_b = 32'd3;
        req(3'd0, 2'd3, 3'd2, 1'b0, 32'h0000_0800, 32'h0000_0C00, '0);
        chk("R7 cmp signed lt", {31'd0, taken}, 32'd1);
        req(3'd0, 2'd3, 3'd4, 1'b0, 32'h0000_0800, 32'h0000_0C00, '0);
        chk("R7 cmp unsigned lt", {31'd0, taken}, 32'd0);
        req(3'd0, 2'd3, 3'd1, 1'b0, 32'h0000_0800, 32'h0000_0C00, '0);
        chk("R7 cmp ne", {31'd0, taken}, 32'd1);
        req(3'd0, 2'd3, 3'd0, 1'b0, 32'h0000_0800, 32'h0000_0C00, '0);
        chk("R7 cmp eq unequal", {31'd0, taken}, 32'd0);
        cmp_b = 32'hFFFF_FFFB;
        req(3'd0, 2'd3, 3'd0, 1'b0, 32'h0000_0800, 32'h0000_0C00, '0);
        chk("R7 cmp eq equal", {31'd0, taken}, 32'd1);
        req(3'd0, 2'd3, 3'd3, 1'b0, 32'h0000_0800, 32'h0000_0C00, '0);
        chk("R7 cmp unsupported sel", {31'd0, taken}, 32'd0);
        cmp_a = '0; cmp_b = '0;
    endtask

    task automatic t_forced();
        flags = 4'b0000;
        req(3'd0, 2'd1, 3'd0, 1'b1, 32'h0000_0600, 32'h0000_7000, '0);
        chk("R8 call overrides false cond", {31'd0, taken}, 32'd1);
        chk("R8 call next", next_ip, 32'h0000_7000);
        req(3'd3, 2'd1, 3'd0, 1'b0, 32'h0000_7010, '0, '0);
        chk("R8 return taken", {31'd0, taken}, 32'd1);
        chk("R9 return to caller", next_ip, 32'h0000_0604);
        idle();
        chk("R10 no error in balanced use", {31'd0, stack_err}, 32'd0);
    endtask

    task automatic t_call_ret();
        for (int i = 0; i < 3; i++) begin
            req(3'd2, 2'd0, 3'd0, 1'b1, 32'h0000_3000 + 32'(i * 'h100), 32'h0000_0080, '0);
        end
        for (int i = 2; i >= 0; i--) begin
            req(3'd3, 2'd0, 3'd0, 1'b0, 32'h0000_9000, '0, '0);
            chk($sformatf("R9 lifo return %0d", i), next_ip, 32'h0000_3004 + 32'(i * 'h100));
        end
    endtask

    task automatic t_vector();
        req(3'd0, 2'd0, 3'd0, 1'b1, 32'h0000_0100, 32'h0000_0400, '0);
        req(3'd4, 2'd1, 3'd0, 1'b0, 32'h0000_0200, 32'h0000_0005, '0);
        chk("R11 busy in request cycle", {31'd0, busy}, 32'd1);
        chk("R11 not taken in request cycle", {31'd0, taken}, 32'd0);
        req(3'd0, 2'd0, 3'd0, 1'b1, 32'h0000_0300, 32'h0000_0999, '0);
        chk("R11 busy clear", {31'd0, busy}, 32'd0);
        chk("R11 taken in result cycle", {31'd0, taken}, 32'd1);
        chk("R11 vector entry", next_ip, VBASE + VSTRIDE * 32'd5);
        req(3'd3, 2'd0, 3'd0, 1'b0, 32'h0000_0500, '0, '0);
        chk("R11 request in result cycle ignored", next_ip, 32'h0000_0104);
        req(3'd4, 2'd0, 3'd0, 1'b0, 32'h0000_0200, 32'h0000_000F, '0);
        idle();
        chk("R11 last vector entry", next_ip, VBASE + VSTRIDE * 32'd15);
    endtask

    task automatic t_underflow();
        idle();
        chk("R10 clean before underflow", {31'd0, stack_err}, 32'd0);
        req(3'd3, 2'd0, 3'd0, 1'b0, 32'h0000_0400, '0, '0);
        chk("R10 empty pop taken", {31'd0, taken}, 32'd1);
        chk("R10 empty pop falls through", next_ip, 32'h0000_0404);
        idle();
        chk("R10 underflow flag", {31'd0, stack_err}, 32'd1);
        idle();
        chk("R10 underflow flag sticky", {31'd0, stack_err}, 32'd1);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 8; i++) begin
            req(3'd0, 2'd0, 3'd0, 1'b1, 32'h0000_1000 + 32'(i * 'h10), 32'h0000_8000, '0);
        end
        idle();
        chk("R10 eight pushes no error", {31'd0, stack_err}, 32'd0);
        req(3'd0, 2'd0, 3'd0, 1'b1, 32'h0000_5000, 32'h0000_8000, '0);
        chk("R10 push when full still taken", {31'd0, taken}, 32'd1);
        idle();
        chk("R10 overflow flag", {31'd0, stack_err}, 32'd1);
        for (int i = 7; i >= 0; i--) begin
            req(3'd3, 2'd0, 3'd0, 1'b0, 32'h0000_6000, '0, '0);
            chk($sformatf("R10 entry %0d kept after overflow", i), next_ip,
                32'h0000_1004 + 32'(i * 'h10));
        end
        req(3'd3, 2'd0, 3'd0, 1'b0, 32'h0000_6000, '0, '0);
        chk("R10 dropped push absent", next_ip, 32'h0000_6004);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        t_reset_state();
        t_abs();
        t_reg();
        t_rel();
        t_flags();
        t_creg();
        t_cmp();
        t_forced();
        t_call_ret();
        t_vector();
        t_underflow();
        do_reset();
        idle();
        chk("R12 error cleared by reset", {31'd0, stack_err}, 32'd0);
        t_overflow();
        idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule